// File: doc/BRIEF.md
# JTAG Host Shift Sequencer

This block acts as the host end of a JTAG link. A controller issues simple commands over a valid/ready handshake. The block turns each command into a run of TCK pulses with the right TMS and TDI values, and it reads back TDO. The commands reset the target's TAP, walk the TAP from Run-Test/Idle into Shift-IR or Shift-DR, shift an instruction word or a data word, and return the TAP to Run-Test/Idle. Bits go out least significant first. Each TDO bit captured during a transfer is stored at the same bit position of the result word.

A data transfer can leave the TAP in Shift-DR when it ends, so a long register can be moved in several pieces. Only the final piece is marked to exit. TCK is derived from the system clock. Each pulse has three phases: a setup phase, a high phase and a low phase. Each phase lasts `clk_div + 1` system clocks. The block also drives an active-low reset line to the target, which follows a request input.

Top module: `jtag_seq_host`

## Requirements
- R1: After reset, tck, tms, tdi and done are 0, cmd_ready is 1, tgt_rst_n is 1 and result is 0.
- R2: Command code 0 (TAP reset) produces exactly five TCK pulses, each with TMS=1 and TDI=0. The result is 0.
- R3: Command code 1 (idle to Shift-IR) produces five pulses with TMS 0,1,1,0,0 in that order and TDI=0. The result is 0.
- R4: Command code 2 (idle to Shift-DR) produces four pulses with TMS 0,1,0,0 and TDI=0. The result is 0.
- R5: Command code 5 (back to Run-Test/Idle) produces two pulses with TMS 1 then 0 and TDI=0. The result is 0.
- R6: Command code 3 shifts cmd_data[3:0], bit 0 first, over four pulses. TMS is 1 only on the fourth pulse. result[3:0] holds the TDO bits taken on pulses 0 to 3, and the upper result bits are 0.
- R7: Command code 4 shifts cmd_len bits of cmd_data, bit 0 first. TMS is 1 on the last pulse only when cmd_exit is 1, and is 0 on every pulse otherwise. result[i] is the TDO bit of pulse i, and bits at or above cmd_len are 0. Lengths from 1 to 32 are allowed.
- R8: Command code 4 with cmd_len=0, and the unused codes 6 and 7, produce no TCK pulse. They raise done in the cycle after acceptance, with result 0.
- R9: Each pulse has a setup, a high and a low phase, each lasting clk_div+1 clocks. TMS and TDI do not change while TCK is high or as it falls. Within one command, successive rising edges are 3*(clk_div+1) clocks apart.
- R10: TDO is sampled at the end of the low phase, after TCK has fallen. done pulses for one cycle, clk_div+1 clocks after the last falling edge. cmd_ready is 0 from acceptance until done, and a cmd_valid seen in that window is ignored, giving no extra pulse and no extra done.
- R11: tgt_rst_n is the inverse of tgt_rst_req, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Phase length minus one, in system clocks; hold it steady while busy |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when a command can be accepted |
| cmd_op | input | 3 | Command code, as listed in the requirements |
| cmd_data | input | MAX_LEN | Bits to shift out, bit 0 first |
| cmd_len | input | LEN_W | Data transfer length in bits; values above MAX_LEN are treated as MAX_LEN |
| cmd_exit | input | 1 | Leave Shift-DR on the last bit of a data transfer |
| done | output | 1 | One-cycle completion strobe |
| result | output | MAX_LEN | Captured TDO bits, valid from done until the next acceptance |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |
| tgt_rst_req | input | 1 | Request to hold the target in reset |
| tgt_rst_n | output | 1 | Active-low target reset |

## Verification
The checker watches the properties that hold on every clock cycle: TMS and TDI stay still while TCK is high and as it falls, TCK stays low whenever the block reports ready, done only appears with ready, and the target reset output follows its request. Other properties only show up over a whole run of pulses, and the scenarios in the bench cover those. These are the exact TMS walk for each command, the order of the shifted bits, the placement of the captured TDO bits, the exit-or-stay choice in Shift-DR, zero-length and unused codes, and commands offered while busy being ignored. The bench also measures phase widths and the pulse period at three divider settings.

// File: rtl/jtag_seq_pkg.sv
package jtag_seq_pkg;

   typedef enum logic [2:0] {
      OP_TAP_RESET   = 3'd0,
      OP_TO_SHIFT_IR = 3'd1,
      OP_TO_SHIFT_DR = 3'd2,
      OP_IR_XFER     = 3'd3,
      OP_DR_XFER     = 3'd4,
      OP_TO_IDLE     = 3'd5,
      OP_RSVD6       = 3'd6,
      OP_RSVD7       = 3'd7
   } jseq_op_e;

   typedef enum logic [1:0] {
      PH_SETUP = 2'd0,
      PH_HIGH  = 2'd1,
      PH_LOW   = 2'd2
   } jseq_phase_e;

   // pulse counts of the fixed TMS walks
   localparam int unsigned RESET_PULSES   = 5;
   localparam int unsigned IR_WALK_PULSES = 5;
   localparam int unsigned DR_WALK_PULSES = 4;
   localparam int unsigned IDLE_PULSES    = 2;

endpackage

// File: rtl/jtag_seq_divider.sv
// Phase timer: tick marks the last system clock of every TCK phase.
module jtag_seq_divider #(
   parameter int unsigned DIV_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_cyc,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == half_cyc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/jtag_seq_pulse.sv
// Three-phase pulse engine: setup (TCK low), high, low; sample at end of low.
module jtag_seq_pulse
   import jtag_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic tck,
   output logic sample
);

   jseq_phase_e phase_q;
   logic        tck_q;

   assign tck    = tck_q;
   assign sample = run && tick && (phase_q == PH_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_SETUP;
         tck_q   <= 1'b0;
      end else if (!run) begin
         phase_q <= PH_SETUP;
         tck_q   <= 1'b0;
      end else if (tick) begin
         case (phase_q)
            PH_SETUP: begin
               phase_q <= PH_HIGH;
               tck_q   <= 1'b1;
            end
            PH_HIGH: begin
               phase_q <= PH_LOW;
               tck_q   <= 1'b0;
            end
            default: begin
               phase_q <= PH_SETUP;
               tck_q   <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/jtag_seq_capture.sv
// Indexed capture of TDO bits; each bit has its own enable decode.
module jtag_seq_capture #(
   parameter int unsigned MAX_LEN = 32,
   parameter int unsigned LEN_W   = 6
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               wr_en,
   input  logic [LEN_W-1:0]   wr_idx,
   input  logic               wr_bit,
   output logic [MAX_LEN-1:0] bits
);

   for (genvar i = 0; i < MAX_LEN; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (clear) begin
            bit_q <= 1'b0;
         end else if (wr_en && (wr_idx == LEN_W'(i))) begin
            bit_q <= wr_bit;
         end
      end
      assign bits[i] = bit_q;
   end

endmodule

// File: rtl/jtag_seq_host.sv
module jtag_seq_host
   import jtag_seq_pkg::*;
#(
   parameter int unsigned MAX_LEN = 32,
   parameter int unsigned IR_W    = 4,
   parameter int unsigned DIV_W   = 8,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIV_W-1:0]   clk_div,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [2:0]         cmd_op,
   input  logic [MAX_LEN-1:0] cmd_data,
   input  logic [LEN_W-1:0]   cmd_len,
   input  logic               cmd_exit,
   output logic               done,
   output logic [MAX_LEN-1:0] result,
   output logic               tck,
   output logic               tms,
   output logic               tdi,
   input  logic               tdo,
   input  logic               tgt_rst_req,
   output logic               tgt_rst_n
);

   // elaboration-time parameter checks
   if (MAX_LEN < RESET_PULSES || MAX_LEN < IR_W) begin : g_bad_len
      $error("jtag_seq_host: MAX_LEN must cover IR_W and the longest TMS walk");
   end
   if (IR_W < 1) begin : g_bad_ir
      $error("jtag_seq_host: IR_W must be at least 1");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("jtag_seq_host: DIV_W must be at least 1");
   end

   function automatic logic pick_tms(input jseq_op_e op, input logic [LEN_W-1:0] idx,
                                     input logic [LEN_W-1:0] n, input logic ext);
      logic fin;
      fin = (idx == n - LEN_W'(1));
      case (op)
         OP_TAP_RESET:   return 1'b1;
         OP_TO_SHIFT_IR: return (idx == LEN_W'(1)) || (idx == LEN_W'(2));
         OP_TO_SHIFT_DR: return (idx == LEN_W'(1));
         OP_TO_IDLE:     return (idx == LEN_W'(0));
         OP_IR_XFER:     return fin;
         OP_DR_XFER:     return ext && fin;
         default:        return 1'b0;
      endcase
   endfunction

   function automatic logic pick_tdi(input jseq_op_e op, input logic [MAX_LEN-1:0] word,
                                     input logic [LEN_W-1:0] idx);
      logic [MAX_LEN-1:0] sh;
      sh = word >> idx;
      if (op == OP_IR_XFER || op == OP_DR_XFER) begin
         return sh[0];
      end
      return 1'b0;
   endfunction

   jseq_op_e           op_in;
   jseq_op_e           op_q;
   logic [LEN_W-1:0]   req_len;
   logic [LEN_W-1:0]   cnt_q;
   logic [LEN_W-1:0]   idx_q;
   logic [LEN_W-1:0]   idx_nxt;
   logic [MAX_LEN-1:0] data_q;
   logic               exit_q;
   logic               busy_q;
   logic               done_q;
   logic               tms_q;
   logic               tdi_q;
   logic               rst_out_q;
   logic               accept;
   logic               last_pulse;
   logic               tick;
   logic               sample;
   logic               shift_op;

   assign op_in      = jseq_op_e'(cmd_op);
   assign accept     = cmd_valid && !busy_q;
   assign idx_nxt    = idx_q + LEN_W'(1);
   assign last_pulse = (idx_q == cnt_q - LEN_W'(1));
   assign shift_op   = (op_q == OP_IR_XFER) || (op_q == OP_DR_XFER);

   always_comb begin
      case (op_in)
         OP_TAP_RESET:   req_len = LEN_W'(RESET_PULSES);
         OP_TO_SHIFT_IR: req_len = LEN_W'(IR_WALK_PULSES);
         OP_TO_SHIFT_DR: req_len = LEN_W'(DR_WALK_PULSES);
         OP_TO_IDLE:     req_len = LEN_W'(IDLE_PULSES);
         OP_IR_XFER:     req_len = LEN_W'(IR_W);
         OP_DR_XFER:     req_len = (cmd_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : cmd_len;
         default:        req_len = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_TAP_RESET;
         cnt_q  <= '0;
         idx_q  <= '0;
         data_q <= '0;
         exit_q <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         tms_q  <= 1'b0;
         tdi_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            op_q   <= op_in;
            cnt_q  <= req_len;
            idx_q  <= '0;
            data_q <= cmd_data;
            exit_q <= cmd_exit;
            if (req_len == '0) begin
               done_q <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               tms_q  <= pick_tms(op_in, '0, req_len, cmd_exit);
               tdi_q  <= pick_tdi(op_in, cmd_data, '0);
            end
         end else if (sample) begin
            if (last_pulse) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               tms_q  <= 1'b0;
               tdi_q  <= 1'b0;
            end else begin
               idx_q <= idx_nxt;
               tms_q <= pick_tms(op_q, idx_nxt, cnt_q, exit_q);
               tdi_q <= pick_tdi(op_q, data_q, idx_nxt);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_out_q <= 1'b1;
      end else begin
         rst_out_q <= ~tgt_rst_req;
      end
   end

   jtag_seq_divider #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy_q),
      .half_cyc (clk_div),
      .tick     (tick)
   );

   jtag_seq_pulse u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy_q),
      .tick   (tick),
      .tck    (tck),
      .sample (sample)
   );

   jtag_seq_capture #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .wr_en  (sample && shift_op),
      .wr_idx (idx_q),
      .wr_bit (tdo),
      .bits   (result)
   );

   assign cmd_ready = !busy_q;
   assign done      = done_q;
   assign tms       = tms_q;
   assign tdi       = tdi_q;
   assign tgt_rst_n = rst_out_q;

endmodule

// File: rtl/jtag_seq_host_chk.sv
module jtag_seq_host_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_ready,
   input logic done,
   input logic tck,
   input logic tms,
   input logic tdi,
   input logic tgt_rst_req,
   input logic tgt_rst_n
);

   // R9: pins hold while TCK is high
   a_r9_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      tck |-> ($stable(tms) && $stable(tdi)));

   // R9: pins hold across the falling edge
   a_r9_hold_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tck) |-> ($stable(tms) && $stable(tdi)));

   // R8: no clock activity while idle
   a_r8_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !tck);

   // R10: a rising TCK edge only happens inside a command
   a_r10_rise_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tck) |-> !cmd_ready);

   // R10: completion coincides with readiness
   a_r10_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready);

   // R11: target reset follows its request one clock later
   a_r11_target_reset: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_rst_n == !$past(tgt_rst_req));

endmodule

bind jtag_seq_host jtag_seq_host_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_ready   (cmd_ready),
   .done        (done),
   .tck         (tck),
   .tms         (tms),
   .tdi         (tdi),
   .tgt_rst_req (tgt_rst_req),
   .tgt_rst_n   (tgt_rst_n)
);

// File: tb/sim_jtag_seq_host.sv
`timescale 1ns/1ps
module sim_jtag_seq_host;

   localparam int MAX_LEN = 32;
   localparam int LEN_W   = 6;
   localparam int DIV_W   = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [DIV_W-1:0]   clk_div = 8'd1;
   logic               cmd_valid = 1'b0;
   logic               cmd_ready;
   logic [2:0]         cmd_op = 3'd0;
   logic [MAX_LEN-1:0] cmd_data = '0;
   logic [LEN_W-1:0]   cmd_len = '0;
   logic               cmd_exit = 1'b0;
   logic               done;
   logic [MAX_LEN-1:0] result;
   logic               tck, tms, tdi;
   logic               tdo = 1'b0;
   logic               tgt_rst_req = 1'b0;
   logic               tgt_rst_n;

   always #10 clk = ~clk;   // 50 MHz

   jtag_seq_host #(.MAX_LEN(MAX_LEN), .IR_W(4), .DIV_W(DIV_W)) u0 (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .cmd_len(cmd_len), .cmd_exit(cmd_exit),
      .done(done), .result(result),
      .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
      .tgt_rst_req(tgt_rst_req), .tgt_rst_n(tgt_rst_n)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int phase_len = 2;
   int pc = 0;
   int last_rise = 0;
   int last_fall = 0;
   int done_cnt = 0;
   logic prev_tck = 1'b0;
   logic [31:0] tdo_pat = '0;

   // scoreboard queues
   bit          q_tms[$];
   bit          q_tdi[$];
   string       q_ptag[$];
   logic [31:0] q_res[$];
   string       q_rtag[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic push_pulse(input bit m, input bit d, input string tag);
      q_tms.push_back(m);
      q_tdi.push_back(d);
      q_ptag.push_back(tag);
   endtask

   // driver: pushes expected pulses and result, then offers the command
   task automatic push_cmd(input int op, input logic [31:0] data, input int len,
                           input bit ext, input logic [31:0] pat, input string tag);
      logic [63:0] mask;
      logic [31:0] res;
      res = '0;
      case (op)
         0: for (int i = 0; i < 5; i++) push_pulse(1'b1, 1'b0, tag);
         1: begin
            push_pulse(0, 0, tag); push_pulse(1, 0, tag); push_pulse(1, 0, tag);
            push_pulse(0, 0, tag); push_pulse(0, 0, tag);
         end
         2: begin
            push_pulse(0, 0, tag); push_pulse(1, 0, tag);
            push_pulse(0, 0, tag); push_pulse(0, 0, tag);
         end
         3: begin
            for (int i = 0; i < 4; i++) push_pulse(i == 3, data[i], tag);
            res = pat & 32'hF;
         end
         4: begin
            for (int i = 0; i < len; i++) push_pulse(ext && (i == len - 1), data[i], tag);
            mask = (64'h1 << len) - 64'h1;
            res = pat & mask[31:0];
         end
         5: begin
            push_pulse(1, 0, tag); push_pulse(0, 0, tag);
         end
         default: res = '0;
      endcase
      q_res.push_back(res);
      q_rtag.push_back(tag);
      @(negedge clk);
      tdo_pat   = pat;
      pc        = 0;
      cmd_op    = op[2:0];
      cmd_data  = data;
      cmd_len   = len[LEN_W-1:0];
      cmd_exit  = ext;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic run_cmd(input int op, input logic [31:0] data, input int len,
                          input bit ext, input logic [31:0] pat, input string tag);
      int d0;
      d0 = done_cnt;
      push_cmd(op, data, len, ext, pat, tag);
      while (done_cnt == d0) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: compares pins and results against the queues
   always @(negedge clk) begin
      bit et, ed;
      string tg;
      logic [31:0] er;
      cyc++;
      if (rst_n) begin
         if (tck && !prev_tck) begin
            if (q_tms.size() == 0) begin
               chk(0, "R10 unexpected TCK pulse", 1, 0);
            end else begin
               et = q_tms.pop_front();
               ed = q_tdi.pop_front();
               tg = q_ptag.pop_front();
               chk(tms == et, {tg, " tms"}, tms, et);
               chk(tdi == ed, {tg, " tdi"}, tdi, ed);
            end
            if (pc > 0) chk(cyc - last_rise == 3 * phase_len, "R9 rise period", cyc - last_rise, 3 * phase_len);
            last_rise = cyc;
         end
         if (!tck && prev_tck) begin
            chk(cyc - last_rise == phase_len, "R9 high width", cyc - last_rise, phase_len);
            if (pc < 32) tdo = tdo_pat[pc];
            pc++;
            last_fall = cyc;
         end
         if (done) begin
            done_cnt++;
            if (q_res.size() == 0) begin
               chk(0, "R10 unexpected done", 1, 0);
            end else begin
               er = q_res.pop_front();
               tg = q_rtag.pop_front();
               chk(result == er, {tg, " result"}, result, er);
               chk(q_tms.size() == 0, {tg, " pulses missing at done"}, q_tms.size(), 0);
            end
            if (pc > 0) chk(cyc - last_fall == phase_len, "R10 done latency", cyc - last_fall, phase_len);
         end
      end
      prev_tck = tck;
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int d0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(tck == 0, "R1 tck", tck, 0);
      chk(tms == 0, "R1 tms", tms, 0);
      chk(tdi == 0, "R1 tdi", tdi, 0);
      chk(done == 0, "R1 done", done, 0);
      chk(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
      chk(tgt_rst_n == 1, "R1 tgt_rst_n", tgt_rst_n, 1);
      chk(result == 0, "R1 result", result, 0);

      run_cmd(0, 32'hFFFF_FFFF, 0, 0, 32'hFFFF_FFFF, "R2");
      run_cmd(1, 32'hFFFF_FFFF, 0, 0, 32'hFFFF_FFFF, "R3");
      run_cmd(3, 32'h0000_000A, 0, 0, 32'hFFFF_FFF5, "R6");
      run_cmd(5, 32'h0, 0, 0, 32'h3, "R5");
      run_cmd(2, 32'h0, 0, 0, 32'hF, "R4");
      run_cmd(4, 32'h0000_00C3, 8, 0, 32'hFFFF_FF96, "R7 stay");
      run_cmd(4, 32'h0000_0ABC, 12, 1, 32'h1234_50F0, "R7 exit");
      run_cmd(5, 32'h0, 0, 0, 32'h0, "R5");

      // R9 fastest divider, full width
      @(negedge clk); clk_div = 8'd0; phase_len = 1;
      run_cmd(2, 32'h0, 0, 0, 32'h0, "R4");
      run_cmd(4, 32'hDEAD_BEEF, 32, 1, 32'h3C5A_96E1, "R7 full");
      run_cmd(3, 32'h0000_0005, 0, 0, 32'h0000_0009, "R6");

      // R9 slower divider, single bit
      @(negedge clk); clk_div = 8'd3; phase_len = 4;
      run_cmd(4, 32'h1, 1, 1, 32'h1, "R7 one bit");

      // R8 empty commands: done on the cycle after acceptance
      for (int k = 0; k < 3; k++) begin
         int op;
         op = (k == 0) ? 4 : 5 + k;
         q_res.push_back('0);
         q_rtag.push_back("R8");
         @(negedge clk);
         pc = 0;
         cmd_op = op[2:0]; cmd_data = 32'hFFFF_FFFF; cmd_len = '0; cmd_exit = 1'b1;
         cmd_valid = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0;
         chk(done == 1, "R8 done next cycle", done, 1);
         repeat (20) @(negedge clk);
      end

      // R10 commands offered while busy are ignored
      @(negedge clk); clk_div = 8'd1; phase_len = 2;
      d0 = done_cnt;
      push_cmd(4, 32'h0000_5A5A, 16, 1, 32'h0000_A5C3, "R10 base");
      repeat (10) @(negedge clk);
      chk(cmd_ready == 0, "R10 ready low while busy", cmd_ready, 0);
      cmd_op = 3'd0; cmd_valid = 1'b1;
      repeat (20) @(negedge clk);
      cmd_valid = 1'b0;
      while (done_cnt == d0) @(negedge clk);
      repeat (60) @(negedge clk);
      chk(done_cnt == d0 + 1, "R10 single done", done_cnt - d0, 1);
      chk(q_tms.size() == 0, "R10 no stray pulses", q_tms.size(), 0);

      // R11 target reset
      tgt_rst_req = 1'b1;
      @(negedge clk);
      chk(tgt_rst_n == 0, "R11 asserted", tgt_rst_n, 0);
      tgt_rst_req = 1'b0;
      @(negedge clk);
      chk(tgt_rst_n == 1, "R11 released", tgt_rst_n, 1);

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule